// File: doc/BRIEF.md
# Interrupt Status and Per-Source Clear Unit

This block collects the event outputs of a two-wire serial bus controller into one interrupt line. There are twelve sources. Ten of them are short event pulses, and each pulse sets a bit that stays set. Two of them are FIFO level conditions, receive-full and transmit-empty, which appear in the status as live levels. A mask register selects which sources may raise the interrupt. The masked status can be read back, and the single active-high interrupt output is driven from it through one register stage.

Each pulse source has its own read-to-clear address. Software reads the status, then reads only the clear addresses of the bits it saw, so an event that arrives between the two reads stays pending. A combined clear address empties every pulse-driven bit at once. When a transmit abort occurs, the block records its reasons in an abort-reason register. That register collects reasons for as long as the abort bit is pending, and it is wiped when the abort bit's clear address is read.

Top module: `irq_ctrl_unit`

## Requirements
- R1: A one-cycle pulse on `evt_pulse[i]` for a pulse source (every bit except 2 and 4) sets raw status bit i at the next clock edge, and the bit stays set until it is cleared. Raw status is read at address 0x34, with source i in data bit i.
- R2: Raw status bit 2 equals `rx_full_lvl` and bit 4 equals `tx_empty_lvl` at all times. No clear read changes these two bits.
- R3: The mask register at 0x30 is read-write over bits 11:0. The masked status at 0x2C reads as raw status AND mask.
- R4: `irq` equals the OR of all masked status bits one clock cycle earlier.
- R5: Each pulse source has a clear address, assigned in ascending bit order starting at 0x44 with a stride of 4: bit0 0x44, bit1 0x48, bit3 0x4C, bit5 0x50, bit6 0x54, bit7 0x58, bit8 0x5C, bit9 0x60, bit10 0x64, bit11 0x68. A read of that address returns the bit's prior value in data bit 0 and clears only that bit.
- R6: If an event pulse arrives in the same cycle as a read of its clear address, or of the combined clear, the bit stays set.
- R7: A read of 0x40 returns in data bit 0 whether any pulse-driven bit was set. It clears all pulse-driven bits and the abort-reason register.
- R8: The abort-reason register at 0x80 ORs in `abrt_reason` in the cycle of a tx-abort pulse (source 6) and in every cycle while raw bit 6 is pending. Only reason bits 0-5, 7 and 9-12 are stored; bits 6 and 8 always read 0.
- R9: A read of the tx-abort clear address 0x54 also wipes the abort-reason register.
- R10: After reset the raw pulse bits, the mask, the abort-reason register and `irq` are all 0.
- R11: Writes to any address other than 0x30 have no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 12 | One-cycle event pulses, indexed by status bit |
| rx_full_lvl | input | 1 | Receive FIFO at threshold (level) |
| tx_empty_lvl | input | 1 | Transmit FIFO at or below threshold (level) |
| abrt_reason | input | 13 | Abort reason bits from the controller |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt request, active high |

## Verification
If a latched bit is lost or not cleared, it shows at the raw status address on the very next read. It also shows on `irq` one cycle after the masked status changes. A wrong clear decode shows up as a neighbouring bit vanishing from raw status, so each clear test reads the full raw vector back, not only the cleared bit. A problem in the abort-reason logic shows when 0x80 is read, and its collection window is tested by driving new reasons after the abort pulse but before the clear.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int NUM_SRC  = 12;
    localparam int ABRT_W   = 13;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 16;
    localparam int NUM_CLR  = 10;

    typedef enum logic [3:0] {
        SRC_RX_UNDER  = 4'd0,
        SRC_RX_OVER   = 4'd1,
        SRC_RX_FULL   = 4'd2,
        SRC_TX_OVER   = 4'd3,
        SRC_TX_EMPTY  = 4'd4,
        SRC_RD_REQ    = 4'd5,
        SRC_TX_ABRT   = 4'd6,
        SRC_RX_DONE   = 4'd7,
        SRC_ACTIVITY  = 4'd8,
        SRC_STOP      = 4'd9,
        SRC_START     = 4'd10,
        SRC_GCALL     = 4'd11
    } irq_src_e;

    localparam logic [NUM_SRC-1:0] LEVEL_SRC_MASK = NUM_SRC'(12'h014);
    localparam logic [NUM_SRC-1:0] LATCH_SRC_MASK = ~LEVEL_SRC_MASK;
    localparam logic [ABRT_W-1:0]  ABRT_KEEP_MASK = ABRT_W'(13'h1EBF);

    localparam logic [ADDR_W-1:0] A_MASKED   = 8'h2C;
    localparam logic [ADDR_W-1:0] A_MASK     = 8'h30;
    localparam logic [ADDR_W-1:0] A_RAW      = 8'h34;
    localparam logic [ADDR_W-1:0] A_CLR_ALL  = 8'h40;
    localparam logic [ADDR_W-1:0] A_CLR_BASE = 8'h44;
    localparam logic [ADDR_W-1:0] A_ABRT     = 8'h80;

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } reg_req_t;

    typedef struct packed {
        logic [NUM_SRC-1:0] bits;
        logic               all;
    } clr_req_t;

    // Clear slot k maps to the k-th pulse-driven status bit in ascending order.
    function automatic int slot_to_bit(input int k);
        if (k < 2)       return k;
        else if (k == 2) return 3;
        else             return k + 2;
    endfunction

    function automatic logic [NUM_SRC-1:0] decode_clear(
        input logic rd, input logic [ADDR_W-1:0] addr);
        logic [NUM_SRC-1:0] v;
        v = '0;
        for (int k = 0; k < NUM_CLR; k++) begin
            if (rd && addr == ADDR_W'(int'(A_CLR_BASE) + 4 * k))
                v[slot_to_bit(k)] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_pulse,
    input  logic               rx_full_lvl,
    input  logic               tx_empty_lvl,
    input  clr_req_t           clr,
    output logic [NUM_SRC-1:0] raw
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (i == int'(SRC_RX_FULL)) begin : g_rxf
            assign raw[i] = rx_full_lvl;
        end else if (i == int'(SRC_TX_EMPTY)) begin : g_txe
            assign raw[i] = tx_empty_lvl;
        end else begin : g_latch
            logic hold_q;
            always_ff @(posedge clk) begin
                if (rst)
                    hold_q <= 1'b0;
                else if (evt_pulse[i])
                    hold_q <= 1'b1;      // new event beats a same-cycle clear
                else if (clr.bits[i] || clr.all)
                    hold_q <= 1'b0;
            end
            assign raw[i] = hold_q;
        end
    end

    logic unused_lvl_evt;
    assign unused_lvl_evt = ^(evt_pulse & LEVEL_SRC_MASK);

endmodule

// File: rtl/irq_abort_log.sv
module irq_abort_log
    import irq_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              abort_evt,
    input  logic              abort_pending,
    input  logic              wipe,
    input  logic [ABRT_W-1:0] reason,
    output logic [ABRT_W-1:0] abrt_src
);

    logic [ABRT_W-1:0] src_q;
    logic [ABRT_W-1:0] src_d;
    logic              collect;

    always_comb begin
        collect = abort_evt || (abort_pending && !wipe);
        src_d   = wipe ? '0 : src_q;
        if (collect)
            src_d = src_d | (reason & ABRT_KEEP_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst) src_q <= '0;
        else     src_q <= src_d;
    end

    assign abrt_src = src_q;

endmodule

// File: rtl/irq_regif.sv
module irq_regif
    import irq_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  reg_req_t           req,
    input  logic [NUM_SRC-1:0] raw,
    input  logic [ABRT_W-1:0]  abrt_src,
    output logic [NUM_SRC-1:0] mask,
    output clr_req_t           clr,
    output logic               abrt_wipe,
    output logic [DATA_W-1:0]  rdata
);

    logic [NUM_SRC-1:0] mask_q;
    logic [DATA_W-1:0]  rdata_q;
    logic [DATA_W-1:0]  rmux;

    always_comb begin
        clr.bits  = decode_clear(req.rd, req.addr);
        clr.all   = req.rd && (req.addr == A_CLR_ALL);
        abrt_wipe = clr.all || clr.bits[SRC_TX_ABRT];
    end

    always_comb begin
        rmux = '0;
        if (req.addr == A_MASKED)
            rmux = DATA_W'(raw & mask_q);
        else if (req.addr == A_MASK)
            rmux = DATA_W'(mask_q);
        else if (req.addr == A_RAW)
            rmux = DATA_W'(raw);
        else if (req.addr == A_ABRT)
            rmux = DATA_W'(abrt_src);
        else if (req.addr == A_CLR_ALL)
            rmux = DATA_W'(|(raw & LATCH_SRC_MASK));
        else if (|decode_clear(1'b1, req.addr))
            rmux = DATA_W'(|(raw & decode_clear(1'b1, req.addr)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (req.wr && req.addr == A_MASK)
                mask_q <= req.wdata[NUM_SRC-1:0];
            if (req.rd)
                rdata_q <= rmux;
        end
    end

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^req.wdata[DATA_W-1:NUM_SRC];

    assign mask  = mask_q;
    assign rdata = rdata_q;

endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
    import irq_ctrl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] evt_pulse,
    input  logic               rx_full_lvl,
    input  logic               tx_empty_lvl,
    input  logic [ABRT_W-1:0]  abrt_reason,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq
);

    reg_req_t           req;
    clr_req_t           clr;
    logic [NUM_SRC-1:0] raw_stat;
    logic [NUM_SRC-1:0] mask_q;
    logic [ABRT_W-1:0]  abrt_src;
    logic               abrt_wipe;
    logic               irq_q;

    assign req = '{rd: reg_rd, wr: reg_wr, addr: reg_addr, wdata: reg_wdata};

    irq_regif u_regif (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .raw       (raw_stat),
        .abrt_src  (abrt_src),
        .mask      (mask_q),
        .clr       (clr),
        .abrt_wipe (abrt_wipe),
        .rdata     (reg_rdata)
    );

    irq_src_bank u_bank (
        .clk          (clk),
        .rst          (rst),
        .evt_pulse    (evt_pulse),
        .rx_full_lvl  (rx_full_lvl),
        .tx_empty_lvl (tx_empty_lvl),
        .clr          (clr),
        .raw          (raw_stat)
    );

    irq_abort_log u_abrt (
        .clk           (clk),
        .rst           (rst),
        .abort_evt     (evt_pulse[SRC_TX_ABRT]),
        .abort_pending (raw_stat[SRC_TX_ABRT]),
        .wipe          (abrt_wipe),
        .reason        (abrt_reason),
        .abrt_src      (abrt_src)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(raw_stat & mask_q);
    end

    assign irq = irq_q;

endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker
    import irq_ctrl_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] evt_pulse,
    input logic               reg_rd,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [NUM_SRC-1:0] raw,
    input logic [NUM_SRC-1:0] mask,
    input logic [ABRT_W-1:0]  abrt_src,
    input logic               irq
);

    logic past_rst_q;
    always_ff @(posedge clk) past_rst_q <= rst;

    // R10: state right after reset
    always @(posedge clk) begin
        if (!rst && past_rst_q) begin
            p_reset_state_r10: assert (((raw & LATCH_SRC_MASK) == '0) && mask == '0
                                       && abrt_src == '0 && irq == 1'b0)
                else $error("reset state wrong");
        end
    end

    p_latch_r1: assert property (@(posedge clk) disable iff (rst)
        (|(evt_pulse & LATCH_SRC_MASK)) |=>
        ((raw & $past(evt_pulse & LATCH_SRC_MASK)) == $past(evt_pulse & LATCH_SRC_MASK)));

    p_irq_follow_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (irq == $past(|(raw & mask))));

    p_clear_rxunder_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 8'h44 && !evt_pulse[0]) |=> !raw[0]);

    p_clear_gcall_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 8'h68 && !evt_pulse[11]) |=> !raw[11]);

    p_evt_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 8'h54 && evt_pulse[6]) |=> raw[6]);

    p_reason_kept_r8: assert property (@(posedge clk) disable iff (rst)
        (abrt_src[6] == 1'b0) && (abrt_src[8] == 1'b0));

    p_abort_wipe_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 8'h54 && !evt_pulse[6]) |=> (abrt_src == '0));

endmodule

bind irq_ctrl_unit irq_ctrl_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_pulse (evt_pulse),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .raw       (raw_stat),
    .mask      (mask_q),
    .abrt_src  (abrt_src),
    .irq       (irq)
);

// File: tb/irq_ctrl_unit_tb_top.sv
module irq_ctrl_unit_tb_top;
    import irq_ctrl_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_SRC-1:0] evt_pulse = '0;
    logic               rx_full_lvl = 1'b0;
    logic               tx_empty_lvl = 1'b0;
    logic [ABRT_W-1:0]  abrt_reason = '0;
    logic               reg_wr = 1'b0;
    logic               reg_rd = 1'b0;
    logic [ADDR_W-1:0]  reg_addr = '0;
    logic [DATA_W-1:0]  reg_wdata = '0;
    logic [DATA_W-1:0]  reg_rdata;
    logic               irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    irq_ctrl_unit dut_i (
        .clk(clk), .rst(rst), .evt_pulse(evt_pulse),
        .rx_full_lvl(rx_full_lvl), .tx_empty_lvl(tx_empty_lvl),
        .abrt_reason(abrt_reason), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic pulse(input logic [11:0] bits);
        @(negedge clk); evt_pulse = bits;
        @(negedge clk); evt_pulse = '0;
    endtask

    task automatic t_reset;
        logic [15:0] d;
        check("R10 irq", irq, 0);
        do_read(8'h34, d); check("R10 raw", d, 16'h0);
        do_read(8'h30, d); check("R10 mask", d, 16'h0);
        do_read(8'h80, d); check("R10 abort", d, 16'h0);
    endtask

    task automatic t_latch;
        logic [15:0] d;
        pulse(12'h201);
        repeat (3) @(negedge clk);
        do_read(8'h34, d); check("R1 raw latched", d, 16'h201);
        check("R4 irq masked off", irq, 0);
    endtask

    task automatic t_mask_irq;
        logic [15:0] d;
        do_write(8'h30, 16'hF200);
        check("R4 irq delayed", irq, 0);
        @(negedge clk); check("R4 irq asserted", irq, 1);
        do_read(8'h2C, d); check("R3 masked", d, 16'h200);
        do_read(8'h30, d); check("R3 mask readback", d, 16'h200);
    endtask

    task automatic t_indiv_clear;
        logic [15:0] d;
        do_read(8'h44, d); check("R5 clr returns set", d, 16'h1);
        do_read(8'h34, d); check("R5 only bit0 cleared", d, 16'h200);
        do_read(8'h44, d); check("R5 clr returns clear", d, 16'h0);
        do_read(8'h60, d); check("R5 stop clr", d, 16'h1);
        do_read(8'h34, d); check("R5 raw empty", d, 16'h0);
        check("R4 irq dropped", irq, 0);
    endtask

    task automatic t_same_cycle;
        logic [15:0] d;
        @(negedge clk); evt_pulse = 12'h200; reg_rd = 1'b1; reg_addr = 8'h60;
        @(negedge clk); evt_pulse = '0; reg_rd = 1'b0;
        do_read(8'h34, d); check("R6 event wins", d, 16'h200);
        @(negedge clk); evt_pulse = 12'h008; reg_rd = 1'b1; reg_addr = 8'h40;
        @(negedge clk); evt_pulse = '0; reg_rd = 1'b0;
        do_read(8'h34, d); check("R6 event wins combined", d, 16'h008);
        do_read(8'h40, d);
    endtask

    task automatic t_levels;
        logic [15:0] d;
        @(negedge clk); rx_full_lvl = 1'b1; tx_empty_lvl = 1'b1;
        do_read(8'h34, d); check("R2 levels shown", d, 16'h014);
        do_read(8'h40, d); check("R7 no latched bits", d, 16'h0);
        do_read(8'h34, d); check("R2 levels survive clear", d, 16'h014);
        @(negedge clk); rx_full_lvl = 1'b0; tx_empty_lvl = 1'b0;
        do_read(8'h34, d); check("R2 levels follow", d, 16'h0);
    endtask

    task automatic t_combined;
        logic [15:0] d;
        @(negedge clk); abrt_reason = 13'h0002;
        pulse(12'h84B);
        abrt_reason = '0;
        do_read(8'h34, d); check("R1 multi latch", d, 16'h84B);
        do_read(8'h40, d); check("R7 combined returns", d, 16'h1);
        do_read(8'h34, d); check("R7 raw cleared", d, 16'h0);
        do_read(8'h80, d); check("R7 abort cleared", d, 16'h0);
    endtask

    task automatic t_abort;
        logic [15:0] d;
        @(negedge clk); abrt_reason = 13'h1001; evt_pulse = 12'h040;
        @(negedge clk); evt_pulse = '0; abrt_reason = 13'h0148;
        @(negedge clk); abrt_reason = '0;
        do_read(8'h80, d); check("R8 reasons collected", d, 16'h1009);
        do_read(8'h54, d); check("R9 abort clr returns", d, 16'h1);
        do_read(8'h34, d); check("R9 abort bit cleared", d, 16'h0);
        do_read(8'h80, d); check("R9 reasons wiped", d, 16'h0);
        @(negedge clk); abrt_reason = 13'h0004;
        @(negedge clk); abrt_reason = '0;
        do_read(8'h80, d); check("R8 no collect idle", d, 16'h0);
    endtask

    task automatic t_ro_write;
        logic [15:0] d;
        do_write(8'h34, 16'h0FFF);
        do_write(8'h80, 16'h1FFF);
        do_write(8'h44, 16'hFFFF);
        do_read(8'h34, d); check("R11 raw unchanged", d, 16'h0);
        do_read(8'h80, d); check("R11 abort unchanged", d, 16'h0);
        do_read(8'h30, d); check("R11 mask unchanged", d, 16'h200);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_latch();
        t_mask_irq();
        t_indiv_clear();
        t_same_cycle();
        t_levels();
        t_combined();
        t_abort();
        t_ro_write();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule